// File: doc/BRIEF.md
# Boundary Scan TAP Controller

This block is a test access port controller in the IEEE 1149.1 style. It runs entirely on the test clock `tck`. A sixteen-state controller follows the mode-select pin `tms`. A 4-bit instruction register picks which data register sits between `tdi` and `tdo`. There are three data registers: a one-bit bypass stage, a 32-bit identification word, and a chain of boundary cells whose length is set by a parameter. Each boundary cell pairs a serial shift flop with a parallel hold stage. The hold stages present their values to the pad logic on `bsr_out`.

Two control outputs go to the pads. `test_mode` tells the pads to drive from `bsr_out` instead of from the core. `force_hiz` overrides every output enable so that all outputs float. `tdo` is paired with an enable, `tdo_oe`. The pad turns the pair into a three-state driver. All pins are plain level signals; there is no stream interface and therefore no back-pressure.

`rst_n` is the asynchronous power-on / hardware reset. `soft_rst` and `stop` are synchronous requests that return the active instruction to the identification code.

Top module: `scan_tap_top`

## Requirements
- R1: The controller has the sixteen standard states and moves on each rising `tck` edge according to `tms`. Five rising edges with `tms` high reach Test-Logic-Reset from any state. In Test-Logic-Reset the active instruction becomes IDCODE.
- R2: While `rst_n` is low, the following hold at once, without a clock: the state is Test-Logic-Reset, the active instruction is IDCODE, the boundary hold stages are 0, and `test_mode`, `force_hiz` and `tdo_oe` are 0.
- R3: When `soft_rst` or `stop` is high at a falling `tck` edge, the active instruction becomes IDCODE (0001) at that edge. The controller state is not changed.
- R4: Capture-IR loads 0001 into the instruction shift stage. Shift-IR moves `tdi` in at bit 3 and presents bit 0 to `tdo`. The falling edge in Update-IR makes the shifted code active.
- R5: Instruction codes are EXTEST=0000, IDCODE=0001, SAMPLE=0010, TRIBYP=0011, SETBYP=0100 and BYPASS=1111. EXTEST and SAMPLE select the boundary chain, IDCODE selects the identification register, and every other code (including reserved ones such as 0101 and 1000) selects bypass.
- R6: With bypass selected, Capture-DR loads 0. A bit entered on `tdi` appears on `tdo` one shift later.
- R7: With IDCODE selected, Capture-DR loads the parameter `ID_VALUE` with bit 0 forced to 1. The word shifts out least significant bit first.
- R8: With the boundary chain selected, Capture-DR loads `pin_in` into the cells. Cell 0 is nearest `tdo` and `tdi` enters cell `BSR_LEN-1`. After `BSR_LEN` shifts, cell i holds the bit that was shifted in at step i.
- R9: The boundary hold stages (`bsr_out`) change only at the falling `tck` edge in Update-DR while the boundary chain is selected. They hold their values under every other instruction, including SETBYP, TRIBYP, BYPASS and reserved codes.
- R10: `test_mode` is 1 exactly when the active instruction is EXTEST or SETBYP.
- R11: `force_hiz` is 1 exactly when the active instruction is TRIBYP. It is never high together with `test_mode`.
- R12: `tdo` and `tdo_oe` change on the falling `tck` edge. `tdo_oe` is 1 only while the state is Shift-IR or Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous power-on / hardware reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in |
| soft_rst | input | 1 | Synchronous soft reset, returns instruction to IDCODE |
| stop | input | 1 | Synchronous stop request, returns instruction to IDCODE |
| pin_in | input | BSR_LEN | Pin values captured by the boundary chain |
| tdo | output | 1 | Serial data out, valid while `tdo_oe` is high |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bsr_out | output | BSR_LEN | Boundary hold-stage values for the pads |
| test_mode | output | 1 | Pads drive from `bsr_out` |
| force_hiz | output | 1 | Global output-enable override (all outputs float) |

## Verification
Every instruction code is loaded, including two reserved codes. For each one, a known pattern is scanned through the data path. The output then separates the three register lengths: a one-bit delay for bypass, a fixed 32-bit word for IDCODE, and the captured `pin_in` for the boundary chain. A test pattern is parked in the hold stages first, and bypass-routed instructions are run after it. This shows which instructions may touch `bsr_out` and which must leave it alone, while `test_mode` and `force_hiz` are read for each code. Random `tms` walks followed by five high clocks, soft reset, stop and an asynchronous reset in the middle of a shift each return the instruction to IDCODE. A random mix of boundary loads and samples with random `pin_in` values checks the chain ordering.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 4;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    TLR, RTI, SEL_DR, CAP_DR, SHF_DR, EX1_DR, PAU_DR, EX2_DR, UPD_DR,
    SEL_IR, CAP_IR, SHF_IR, EX1_IR, PAU_IR, EX2_IR, UPD_IR
  } tap_state_e;

  localparam logic [IR_W-1:0] IR_EXTEST = 4'b0000;
  localparam logic [IR_W-1:0] IR_IDCODE = 4'b0001;
  localparam logic [IR_W-1:0] IR_SAMPLE = 4'b0010;
  localparam logic [IR_W-1:0] IR_TRIBYP = 4'b0011;
  localparam logic [IR_W-1:0] IR_SETBYP = 4'b0100;
  localparam logic [IR_W-1:0] IR_BYPASS = 4'b1111;
  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;

  typedef enum logic [1:0] {DR_BYPASS, DR_IDENT, DR_BOUND} dr_sel_e;

  function automatic tap_state_e tap_next(tap_state_e s, logic m);
    case (s)
      TLR:     return m ? TLR    : RTI;
      RTI:     return m ? SEL_DR : RTI;
      SEL_DR:  return m ? SEL_IR : CAP_DR;
      CAP_DR:  return m ? EX1_DR : SHF_DR;
      SHF_DR:  return m ? EX1_DR : SHF_DR;
      EX1_DR:  return m ? UPD_DR : PAU_DR;
      PAU_DR:  return m ? EX2_DR : PAU_DR;
      EX2_DR:  return m ? UPD_DR : SHF_DR;
      UPD_DR:  return m ? SEL_DR : RTI;
      SEL_IR:  return m ? TLR    : CAP_IR;
      CAP_IR:  return m ? EX1_IR : SHF_IR;
      SHF_IR:  return m ? EX1_IR : SHF_IR;
      EX1_IR:  return m ? UPD_IR : PAU_IR;
      PAU_IR:  return m ? EX2_IR : PAU_IR;
      EX2_IR:  return m ? UPD_IR : SHF_IR;
      default: return m ? SEL_DR : RTI;
    endcase
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) state <= TLR;
    else        state <= tap_next(state, tms);
  end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            rst_n,
  input  logic            soft_rst,
  input  logic            stop,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_shift,
  output logic [IR_W-1:0] ir_active,
  output dr_sel_e         dr_sel,
  output logic            test_mode,
  output logic            force_hiz
);

  // shift stage: rising edge
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                ir_shift <= IR_CAPTURE;
    else if (state == CAP_IR)  ir_shift <= IR_CAPTURE;
    else if (state == SHF_IR)  ir_shift <= {tdi, ir_shift[IR_W-1:1]};
  end

  // active stage: falling edge
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)                                      ir_active <= IR_IDCODE;
    else if (soft_rst || stop || state == TLR)       ir_active <= IR_IDCODE;
    else if (state == UPD_IR)                        ir_active <= ir_shift;
  end

  always_comb begin
    dr_sel    = DR_BYPASS;
    test_mode = 1'b0;
    force_hiz = 1'b0;
    case (ir_active)
      IR_EXTEST: begin dr_sel = DR_BOUND; test_mode = 1'b1; end
      IR_SAMPLE: dr_sel = DR_BOUND;
      IR_IDCODE: dr_sel = DR_IDENT;
      IR_SETBYP: test_mode = 1'b1;
      IR_TRIBYP: force_hiz = 1'b1;
      default:   dr_sel = DR_BYPASS;
    endcase
  end

endmodule

// File: rtl/scan_bsr_cell.sv
module scan_bsr_cell (
  input  logic tck,
  input  logic rst_n,
  input  logic cap_en,
  input  logic shift_en,
  input  logic upd_en,
  input  logic par_in,
  input  logic ser_in,
  output logic ser_out,
  output logic par_out
);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)        ser_out <= 1'b0;
    else if (cap_en)   ser_out <= par_in;
    else if (shift_en) ser_out <= ser_in;
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n)      par_out <= 1'b0;
    else if (upd_en) par_out <= ser_out;
  end

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int              BSR_LEN  = 16,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_3E02
) (
  input  logic               tck,
  input  logic               rst_n,
  input  tap_state_e         state,
  input  dr_sel_e            dr_sel,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               dr_so,
  output logic [BSR_LEN-1:0] bsr_out
);

  localparam logic [ID_W-1:0] ID_CAP = ID_VALUE | {{(ID_W-1){1'b0}}, 1'b1};

  logic            byp_q;
  logic [ID_W-1:0] id_sr;
  logic [BSR_LEN:0] chain;

  wire cap  = (state == CAP_DR);
  wire shf  = (state == SHF_DR);
  wire upd  = (state == UPD_DR);
  wire bsel = (dr_sel == DR_BOUND);

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) byp_q <= 1'b0;
    else if (dr_sel == DR_BYPASS) begin
      if (cap)      byp_q <= 1'b0;
      else if (shf) byp_q <= tdi;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) id_sr <= ID_CAP;
    else if (dr_sel == DR_IDENT) begin
      if (cap)      id_sr <= ID_CAP;
      else if (shf) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  assign chain[BSR_LEN] = tdi;

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
    scan_bsr_cell u_cell (
      .tck      (tck),
      .rst_n    (rst_n),
      .cap_en   (cap && bsel),
      .shift_en (shf && bsel),
      .upd_en   (upd && bsel),
      .par_in   (pin_in[i]),
      .ser_in   (chain[i+1]),
      .ser_out  (chain[i]),
      .par_out  (bsr_out[i])
    );
  end

  always_comb begin
    case (dr_sel)
      DR_IDENT: dr_so = id_sr[0];
      DR_BOUND: dr_so = chain[0];
      default:  dr_so = byp_q;
    endcase
  end

endmodule

// File: rtl/scan_tap_top.sv
module scan_tap_top
  import scan_tap_pkg::*;
#(
  parameter int              BSR_LEN  = 16,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_3E02
) (
  input  logic               tck,
  input  logic               rst_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic               soft_rst,
  input  logic               stop,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic               tdo,
  output logic               tdo_oe,
  output logic [BSR_LEN-1:0] bsr_out,
  output logic               test_mode,
  output logic               force_hiz
);

  tap_state_e      state;
  dr_sel_e         dr_sel;
  logic [IR_W-1:0] ir_shift;
  logic [IR_W-1:0] ir_active;
  logic            dr_so;

  scan_tap_fsm u_fsm (
    .tck   (tck),
    .rst_n (rst_n),
    .tms   (tms),
    .state (state)
  );

  scan_tap_ir u_ir (
    .tck       (tck),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst),
    .stop      (stop),
    .state     (state),
    .tdi       (tdi),
    .ir_shift  (ir_shift),
    .ir_active (ir_active),
    .dr_sel    (dr_sel),
    .test_mode (test_mode),
    .force_hiz (force_hiz)
  );

  scan_tap_dr #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) u_dr (
    .tck     (tck),
    .rst_n   (rst_n),
    .state   (state),
    .dr_sel  (dr_sel),
    .tdi     (tdi),
    .pin_in  (pin_in),
    .dr_so   (dr_so),
    .bsr_out (bsr_out)
  );

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= (state == SHF_IR) ? ir_shift[0] : dr_so;
      tdo_oe <= (state == SHF_IR) || (state == SHF_DR);
    end
  end

endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
  import scan_tap_pkg::*;
#(
  parameter int BSR_LEN = 16
) (
  input logic               tck,
  input logic               rst_n,
  input logic               tms,
  input logic               soft_rst,
  input logic               stop,
  input tap_state_e         state,
  input logic [IR_W-1:0]    ir_shift,
  input logic [IR_W-1:0]    ir_active,
  input logic               tdo_oe,
  input logic [BSR_LEN-1:0] bsr_out,
  input logic               test_mode,
  input logic               force_hiz
);

  AST_SELIR_TMS_TO_RESET: assert property (@(posedge tck) disable iff (!rst_n)
    (state == SEL_IR && tms) |=> (state == TLR)); // R1

  AST_CAPIR_PATTERN: assert property (@(posedge tck) disable iff (!rst_n)
    (state == CAP_IR) |=> (ir_shift == IR_CAPTURE)); // R4

  AST_SOFT_STOP_IDCODE: assert property (@(negedge tck) disable iff (!rst_n)
    (soft_rst || stop) |=> (ir_active == IR_IDCODE)); // R3

  AST_LATCH_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    (state != UPD_DR) |-> $stable(bsr_out)); // R9

  AST_HIZ_NOT_TEST: assert property (@(posedge tck) disable iff (!rst_n)
    !(force_hiz && test_mode)); // R11

  AST_OE_ONLY_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
    tdo_oe |-> (state == SHF_IR || state == SHF_DR)); // R12

endmodule

bind scan_tap_top scan_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck       (tck),
  .rst_n     (rst_n),
  .tms       (tms),
  .soft_rst  (soft_rst),
  .stop      (stop),
  .state     (state),
  .ir_shift  (ir_shift),
  .ir_active (ir_active),
  .tdo_oe    (tdo_oe),
  .bsr_out   (bsr_out),
  .test_mode (test_mode),
  .force_hiz (force_hiz)
);

// File: tb/scan_tap_top_test.sv
module scan_tap_top_test;

  localparam int          TCK_PERIOD = 20;
  localparam int          BSR_LEN    = 16;
  localparam logic [31:0] ID_VALUE   = 32'h1A5C_3E02;
  localparam logic [31:0] ID_EXP     = ID_VALUE | 32'h1;

  logic tck = 1'b0, rst_n, tms, tdi, soft_rst, stop;
  logic [BSR_LEN-1:0] pin_in;
  logic tdo, tdo_oe, test_mode, force_hiz;
  logic [BSR_LEN-1:0] bsr_out;

  int n_cmp = 0, n_bad = 0;
  logic oe_in_shift, oe_after_shift;

  scan_tap_top #(.BSR_LEN(BSR_LEN), .ID_VALUE(ID_VALUE)) uut (
    .tck(tck), .rst_n(rst_n), .tms(tms), .tdi(tdi), .soft_rst(soft_rst),
    .stop(stop), .pin_in(pin_in), .tdo(tdo), .tdo_oe(tdo_oe),
    .bsr_out(bsr_out), .test_mode(test_mode), .force_hiz(force_hiz)
  );

  always #(TCK_PERIOD/2) tck = ~tck;

  function automatic logic [63:0] mask(int n);
    return (64'd1 << n) - 64'd1;
  endfunction

  function automatic logic [63:0] bypass_exp(logic [63:0] din, int n);
    return (din << 1) & mask(n);
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge tck); @(negedge tck); #1;
  endtask

  // from Run-Test/Idle, back to Run-Test/Idle
  task automatic load_ir(input logic [3:0] code, output logic [3:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 4; i++) begin
      cap[i] = tdo;
      tick(i == 3, code[i]);
    end
    tick(1, 0); tick(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    oe_in_shift = tdo_oe;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tick(i == n - 1, din[i]);
    end
    oe_after_shift = tdo_oe;
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #(TCK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [3:0]  cap;
    logic [63:0] dout, din;
    logic [BSR_LEN-1:0] park;
    void'($urandom(32'd7391));
    rst_n = 0; tms = 1; tdi = 0; soft_rst = 0; stop = 0; pin_in = '0;
    #(TCK_PERIOD * 2 + 1);
    // R2 reset state
    chk("R2 test_mode", test_mode, 0);
    chk("R2 force_hiz", force_hiz, 0);
    chk("R2 tdo_oe", tdo_oe, 0);
    chk("R2 bsr_out", bsr_out, 0);
    @(negedge tck); rst_n = 1; #1;
    tick(0, 0);
    // R7 / R2: IDCODE is active after reset
    scan_dr(32, 64'hFFFF_FFFF, dout);
    chk("R7 idcode word", dout, ID_EXP);
    chk("R12 oe in shift", oe_in_shift, 1);
    chk("R12 oe after shift", oe_after_shift, 0);
    // R4 / R6 bypass
    load_ir(4'b1111, cap);
    chk("R4 capture-ir", cap, 4'b0001);
    din = 64'hB3C5;
    scan_dr(16, din, dout);
    chk("R6 bypass delay", dout, bypass_exp(din, 16));
    chk("R10 bypass normal", test_mode, 0);
    // R8 sample
    load_ir(4'b0010, cap);
    pin_in = 16'h5AC3;
    din = 64'h0F0F;
    scan_dr(BSR_LEN, din, dout);
    chk("R8 sample capture", dout, 64'h5AC3);
    chk("R10 sample normal", test_mode, 0);
    chk("R9 sample update", bsr_out, 16'h0F0F);
    // R9/R10 extest
    load_ir(4'b0000, cap);
    pin_in = 16'h9E21;
    park = 16'hA55A;
    scan_dr(BSR_LEN, {48'd0, park}, dout);
    chk("R8 extest capture", dout, 64'h9E21);
    chk("R9 extest update", bsr_out, park);
    chk("R10 extest test_mode", test_mode, 1);
    // R5/R9/R10 setbyp
    load_ir(4'b0100, cap);
    din = 64'h3C96;
    scan_dr(16, din, dout);
    chk("R5 setbyp bypass", dout, bypass_exp(din, 16));
    chk("R10 setbyp test_mode", test_mode, 1);
    chk("R9 setbyp hold", bsr_out, park);
    // R11 tribyp
    load_ir(4'b0011, cap);
    chk("R11 tribyp hiz", force_hiz, 1);
    chk("R11 tribyp not test", test_mode, 0);
    din = 64'h7E11;
    scan_dr(16, din, dout);
    chk("R5 tribyp bypass", dout, bypass_exp(din, 16));
    chk("R9 tribyp hold", bsr_out, park);
    // R5 reserved codes
    foreach (cap[k]) ;
    for (int r = 0; r < 2; r++) begin
      load_ir(r == 0 ? 4'b0101 : 4'b1000, cap);
      din = 64'hC3E7 ^ r;
      scan_dr(16, din, dout);
      chk("R5 reserved bypass", dout, bypass_exp(din, 16));
      chk("R5 reserved normal", {test_mode, force_hiz}, 0);
      chk("R9 reserved hold", bsr_out, park);
    end
    // R3 soft reset and stop
    load_ir(4'b1111, cap);
    soft_rst = 1; tick(0, 0); soft_rst = 0;
    scan_dr(32, 64'h0, dout);
    chk("R3 soft_rst idcode", dout, ID_EXP);
    load_ir(4'b0000, cap);
    stop = 1; tick(0, 0); stop = 0;
    chk("R3 stop leaves test", test_mode, 0);
    scan_dr(32, 64'h0, dout);
    chk("R3 stop idcode", dout, ID_EXP);
    // R1 random walks then five TMS-high clocks
    for (int w = 0; w < 8; w++) begin
      load_ir(4'b0100, cap);
      for (int s = 0; s < int'($urandom_range(3, 20)); s++) tick($urandom() & 1, $urandom() & 1);
      for (int s = 0; s < 5; s++) tick(1, 0);
      chk("R1 reset path mode", {test_mode, force_hiz}, 0);
      tick(0, 0);
      scan_dr(32, 64'h0, dout);
      chk("R1 reset path idcode", dout, ID_EXP);
    end
    // R8/R9 random loads and samples
    for (int it = 0; it < 20; it++) begin
      logic [BSR_LEN-1:0] pat, pins;
      pat = BSR_LEN'($urandom()); pins = BSR_LEN'($urandom());
      load_ir(($urandom() & 1) ? 4'b0000 : 4'b0010, cap);
      pin_in = pins;
      scan_dr(BSR_LEN, {48'd0, pat}, dout);
      chk("R8 random capture", dout, {48'd0, pins});
      chk("R9 random update", bsr_out, pat);
    end
    // R2 async reset in the middle of a shift
    load_ir(4'b0000, cap);
    tick(1, 0); tick(0, 0); tick(0, 0); tick(0, 1);
    #3 rst_n = 0; #1;
    chk("R2 async tdo_oe", tdo_oe, 0);
    chk("R2 async bsr_out", bsr_out, 0);
    chk("R2 async test_mode", test_mode, 0);
    @(negedge tck); rst_n = 1; #1;
    tick(0, 0);
    scan_dr(32, 64'h0, dout);
    chk("R2 async idcode", dout, ID_EXP);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule